// File: doc/BRIEF.md
# Triple Interval Timer Counter

This peripheral holds three independent 16-bit timer channels behind one 32-bit single-cycle register bus. Every channel has a power-of-two prescaler and counts up or down. It wraps either at the full 16-bit range or at a programmed interval limit. Three comparators raise flags when the count steps onto their values. Flags collect in a six-bit status register that clears when read, and a per-channel enable mask turns the flags into one interrupt line per channel.

Software reaches all three channels through one address window. The registers of the channels are interleaved one word apart: the word address modulo three picks the channel, and the word address divided by three picks the register kind. Read data is combinational in the same cycle as the access. Writes and read-clears take effect at the next rising clock edge. The event control register is plain storage, and the event value register reads as zero.

Top module: `tri_timer`

## Requirements
- R1: With the clock-config bit 0 clear, an enabled counter steps on every clock. With bit 0 set and the field N in bits 4:1, it steps once every 2^(N+1) clocks. The divider restarts from zero while the channel is disabled.
- R2: Counter control bits are: bit 0 disable, bit 1 interval mode, bit 2 count down, bit 3 match enable. Writing bit 4 as 1 clears the count and is not stored, so it reads back as 0. The register resets to 0x21, and a disabled channel holds its count.
- R3: When counting up, the count wraps to 0 on the step after it reaches the wrap limit. The limit is the interval register in interval mode and 0xFFFF otherwise. The wrap sets status bit 0 in interval mode and status bit 4 otherwise.
- R4: When counting down, a step from 0 loads the wrap limit and sets the same mode-dependent wrap flag as R3.
- R5: With match enable set, a step that lands on match register i (i = 1..3) sets status bit i. A match value above the current wrap limit never sets its flag.
- R6: A read of the status register returns its contents and clears it. A flag raised in the same cycle as the read survives it. Writes to the status register have no effect.
- R7: Each channel's interrupt output is high exactly when some status bit is set together with the same bit of that channel's six-bit enable register.
- R8: For a byte address A, the word W = A/4 selects channel W mod 3 and register kind W div 3. The kinds, in order 0..10, are: clock config, counter control, count value, interval, match 1, match 2, match 3, status, enable, event control, event value.
- R9: Interval and match registers keep 16 bits, clock config and enable keep 6, and event control keeps 3. The count value and event value are read-only, and event value reads 0. Words at kind 11 or above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (8) | Byte address |
| busWdata | input | DATA_W (32) | Write data |
| busRdata | output | DATA_W (32) | Read data, valid in the access cycle |
| irq | output | NCH (3) | One interrupt line per channel |

## Verification
The counters run in several modes against a behavioural model:
- an interval wrap with prescale by 4 and up counting, which separates the divider ratio from the wrap point;
- a down-counting interval with one match placed above the limit, which shows whether that match is gated;
- a full 16-bit up run and a down step from zero, which tell the overflow flag apart from the interval flag;
- a second prescale ratio of 8.

A zero interval while counting down raises a flag on every cycle, so back-to-back status reads show whether a flag set during a read-clear survives. A sweep over the whole address window, plus reads and writes outside it, exposes a wrong modulo-three decode or a register mask that is too wide.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  parameter int CNT_W  = 16;  // counter, interval and match width
  parameter int NMATCH = 3;   // comparators per channel
  parameter int CFG_W  = 6;   // clock config / control / status / enable width
  parameter int EVC_W  = 3;   // event control width
  parameter int PSV_W  = 4;   // prescale exponent field width
  localparam int PRE_W = 2 ** PSV_W;  // divider counter width

  // counter control bit positions
  localparam int CTL_DIS  = 0;
  localparam int CTL_INTV = 1;
  localparam int CTL_DOWN = 2;
  localparam int CTL_MEN  = 3;
  localparam int CTL_CLR  = 4;

  // status bit positions
  localparam int ST_INTV_WRAP = 0;
  localparam int ST_MATCH0    = 1;
  localparam int ST_OVF       = 4;

  // register kinds (word index divided by channel count)
  localparam int K_CLK   = 0;
  localparam int K_CTRL  = 1;
  localparam int K_COUNT = 2;
  localparam int K_INTV  = 3;
  localparam int K_MATCH = 4;
  localparam int K_STAT  = K_MATCH + NMATCH;
  localparam int K_EN    = K_STAT + 1;
  localparam int K_EVC   = K_EN + 1;
  localparam int K_EVV   = K_EVC + 1;
  localparam int NKIND   = K_EVV + 1;

  typedef struct packed {
    logic              wrClk;
    logic              wrCtrl;
    logic              wrIntv;
    logic [NMATCH-1:0] wrMatch;
    logic              wrEn;
    logic              wrEvt;
    logic              rdStat;
  } chanStrobeT;

  typedef struct packed {
    logic [CFG_W-1:0]        clkCfg;
    logic [CFG_W-1:0]        ctrl;
    logic [CNT_W-1:0]        count;
    logic [CNT_W-1:0]        intv;
    logic [NMATCH*CNT_W-1:0] match;
    logic [CFG_W-1:0]        status;
    logic [CFG_W-1:0]        enable;
    logic [EVC_W-1:0]        evtCtl;
  } chanViewT;
endpackage

// File: rtl/tri_timer_ctrl.sv
module tri_timer_ctrl
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCH    = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  chanViewT [NCH-1:0]     views,
  output chanStrobeT [NCH-1:0]   strb,
  output logic [DATA_W-1:0]      busRdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic [WORD_W-1:0] chanIdx;
  logic [WORD_W-1:0] kindIdx;
  logic              mapped;
  logic [NCH-1:0]    rdStatVec;
  chanViewT          selView;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign chanIdx = wordIdx % WORD_W'(NCH);
  assign kindIdx = wordIdx / WORD_W'(NCH);
  assign mapped  = kindIdx < WORD_W'(NKIND);

  // strobe generation: one channel, one kind per access
  always_comb begin
    strb = '0;
    for (int c = 0; c < NCH; c++) begin
      if (busSel && mapped && chanIdx == WORD_W'(c)) begin
        strb[c].wrClk  = busWrite && kindIdx == WORD_W'(K_CLK);
        strb[c].wrCtrl = busWrite && kindIdx == WORD_W'(K_CTRL);
        strb[c].wrIntv = busWrite && kindIdx == WORD_W'(K_INTV);
        strb[c].wrEn   = busWrite && kindIdx == WORD_W'(K_EN);
        strb[c].wrEvt  = busWrite && kindIdx == WORD_W'(K_EVC);
        strb[c].rdStat = !busWrite && kindIdx == WORD_W'(K_STAT);
        for (int m = 0; m < NMATCH; m++)
          strb[c].wrMatch[m] = busWrite && kindIdx == WORD_W'(K_MATCH + m);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) rdStatVec[c] = strb[c].rdStat;
  end

  // read mux
  always_comb begin
    selView  = views[0];
    for (int c = 0; c < NCH; c++)
      if (chanIdx == WORD_W'(c)) selView = views[c];
    busRdata = '0;
    if (busSel && !busWrite && mapped) begin
      if (kindIdx == WORD_W'(K_CLK))        busRdata = DATA_W'(selView.clkCfg);
      else if (kindIdx == WORD_W'(K_CTRL))  busRdata = DATA_W'(selView.ctrl);
      else if (kindIdx == WORD_W'(K_COUNT)) busRdata = DATA_W'(selView.count);
      else if (kindIdx == WORD_W'(K_INTV))  busRdata = DATA_W'(selView.intv);
      else if (kindIdx == WORD_W'(K_STAT))  busRdata = DATA_W'(selView.status);
      else if (kindIdx == WORD_W'(K_EN))    busRdata = DATA_W'(selView.enable);
      else if (kindIdx == WORD_W'(K_EVC))   busRdata = DATA_W'(selView.evtCtl);
      else begin
        for (int m = 0; m < NMATCH; m++)
          if (kindIdx == WORD_W'(K_MATCH + m))
            busRdata = DATA_W'(selView.match[m*CNT_W +: CNT_W]);
      end
    end
  end

  // R8: a status read touches at most one channel
  a_r8_single_channel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdStatVec));

  // R9: words beyond the last register kind read as zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && kindIdx >= WORD_W'(NKIND)) |-> busRdata == '0);
endmodule

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanStrobeT       strb,
  input  logic [CNT_W-1:0] wdata,
  output chanViewT         view,
  output logic             irq
);
  localparam logic [CFG_W-1:0] CTRL_RST  = CFG_W'(6'h21);
  localparam logic [CFG_W-1:0] CTRL_MASK = ~(CFG_W'(1) << CTL_CLR);

  logic [CFG_W-1:0] clkCfgQ, ctrlQ, statusQ, enableQ;
  logic [EVC_W-1:0] evtCtlQ;
  logic [CNT_W-1:0] countQ, intvQ;
  logic [CNT_W-1:0] matchQ [NMATCH];
  logic [PRE_W-1:0] preQ;

  logic [PSV_W-1:0] psVal;
  logic [PRE_W-1:0] preMask;
  logic             tick, clrNow, advance, downMode, wrapNow;
  logic [CNT_W-1:0] top, nextCount;
  logic [CFG_W-1:0] setBits;

  // divider
  assign psVal   = clkCfgQ[PSV_W:1];
  assign preMask = ~({PRE_W{1'b1}} << ({1'b0, psVal} + 1'b1));
  assign tick    = ~clkCfgQ[0] | ((preQ & preMask) == preMask);

  // step control
  assign clrNow   = strb.wrCtrl & wdata[CTL_CLR];
  assign advance  = ~ctrlQ[CTL_DIS] & ~clrNow & tick;
  assign downMode = ctrlQ[CTL_DOWN];
  assign top      = ctrlQ[CTL_INTV] ? intvQ : {CNT_W{1'b1}};
  assign wrapNow  = downMode ? (countQ == '0) : (countQ >= top);

  always_comb begin
    if (downMode) nextCount = wrapNow ? top : countQ - 1'b1;
    else          nextCount = wrapNow ? '0  : countQ + 1'b1;
  end

  // flag sources
  always_comb begin
    setBits = '0;
    if (advance && wrapNow) begin
      if (ctrlQ[CTL_INTV]) setBits[ST_INTV_WRAP] = 1'b1;
      else                 setBits[ST_OVF]       = 1'b1;
    end
  end

  logic [NMATCH-1:0] matchHit;
  genvar gm;
  generate
    for (gm = 0; gm < NMATCH; gm++) begin : g_cmp
      assign matchHit[gm] = advance && ctrlQ[CTL_MEN] &&
                            (matchQ[gm] <= top) && (nextCount == matchQ[gm]);
    end
  endgenerate

  logic [CFG_W-1:0] allSet;
  always_comb begin
    allSet = setBits;
    allSet[ST_MATCH0 +: NMATCH] = matchHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ   <= '0;
      countQ <= '0;
    end else begin
      if (clrNow || ctrlQ[CTL_DIS]) preQ <= '0;
      else                          preQ <= preQ + 1'b1;
      if (clrNow)       countQ <= '0;
      else if (advance) countQ <= nextCount;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (strb.rdStat ? '0 : statusQ) | allSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkCfgQ <= '0;
      ctrlQ   <= CTRL_RST;
      intvQ   <= '0;
      enableQ <= '0;
      evtCtlQ <= '0;
      for (int m = 0; m < NMATCH; m++) matchQ[m] <= '0;
    end else begin
      if (strb.wrClk)  clkCfgQ <= wdata[CFG_W-1:0];
      if (strb.wrCtrl) ctrlQ   <= wdata[CFG_W-1:0] & CTRL_MASK;
      if (strb.wrIntv) intvQ   <= wdata;
      if (strb.wrEn)   enableQ <= wdata[CFG_W-1:0];
      if (strb.wrEvt)  evtCtlQ <= wdata[EVC_W-1:0];
      for (int m = 0; m < NMATCH; m++)
        if (strb.wrMatch[m]) matchQ[m] <= wdata;
    end
  end

  always_comb begin
    view.clkCfg = clkCfgQ;
    view.ctrl   = ctrlQ;
    view.count  = countQ;
    view.intv   = intvQ;
    view.status = statusQ;
    view.enable = enableQ;
    view.evtCtl = evtCtlQ;
    for (int m = 0; m < NMATCH; m++) view.match[m*CNT_W +: CNT_W] = matchQ[m];
  end

  assign irq = |(statusQ & enableQ);

  // R2: a disabled channel keeps its count unless it is cleared
  a_r2_frozen_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ[CTL_DIS] && !clrNow) |=> $stable(countQ));

  // R3: up-count wrap returns to zero
  a_r3_up_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !downMode && countQ >= top) |=> countQ == '0);

  // R4: down-count wrap loads the limit
  a_r4_down_wrap_top: assert property (@(posedge clk) disable iff (!rstN)
    (advance && downMode && countQ == '0) |=> countQ == $past(top));

  // R6: a read with no new flag leaves the status empty
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStat && allSet == '0) |=> statusQ == '0);

  // R6: a flag raised during a read-clear survives
  a_r6_keep_new_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStat && allSet != '0) |=> statusQ != '0);
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCH    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NCH-1:0]    irq
);
  chanStrobeT [NCH-1:0] strb;
  chanViewT   [NCH-1:0] views;

  tri_timer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .views    (views),
    .strb     (strb),
    .busRdata (busRdata)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NCH; gc++) begin : g_chan
      tri_timer_chan u_chan (
        .clk   (clk),
        .rstN  (rstN),
        .strb  (strb[gc]),
        .wdata (busWdata[CNT_W-1:0]),
        .view  (views[gc]),
        .irq   (irq[gc])
      );
    end
  endgenerate
endmodule

// File: tb/tri_timer_tb.sv
module tri_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  irq;

  int total = 0;
  int bad = 0;
  string curReq = "R2";

  // behavioural model state
  int mClk[3], mCtl[3], mCnt[3], mPre[3], mIntv[3], mStat[3], mEn[3], mEvc[3];
  int mMat[3][3];

  tri_timer u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic modelReset();
    for (int c = 0; c < 3; c++) begin
      mClk[c] = 0; mCtl[c] = 'h21; mCnt[c] = 0; mPre[c] = 0; mIntv[c] = 0;
      mStat[c] = 0; mEn[c] = 0; mEvc[c] = 0;
      for (int i = 0; i < 3; i++) mMat[c][i] = 0;
    end
  endtask

  function automatic int modelRead(int addr);
    int w, ch, k;
    w = addr / 4; ch = w % 3; k = w / 3;
    case (k)
      0: return mClk[ch];
      1: return mCtl[ch];
      2: return mCnt[ch];
      3: return mIntv[ch];
      4, 5, 6: return mMat[ch][k-4];
      7: return mStat[ch];
      8: return mEn[ch];
      9: return mEvc[ch];
      default: return 0;
    endcase
  endfunction

  initial modelReset();

  always @(posedge clk) begin
    int w, ch, k, top, n;
    bit tick, wrap;
    if (!rstN) modelReset();
    else begin
      w = busAddr / 4; ch = w % 3; k = w / 3;
      for (int c = 0; c < 3; c++) begin
        if (busSel && !busWrite && k == 7 && ch == c) mStat[c] = 0;
        tick = 0;
        if (busSel && busWrite && k == 1 && ch == c && busWdata[4]) begin
          mCnt[c] = 0; mPre[c] = 0;
        end else if (mCtl[c] & 1) mPre[c] = 0;
        else if (mClk[c] & 1) begin
          n = (mClk[c] >> 1) & 15;
          mPre[c]++;
          if (mPre[c] == (1 << (n + 1))) begin mPre[c] = 0; tick = 1; end
        end else tick = 1;
        if (tick) begin
          top = (mCtl[c] & 2) ? mIntv[c] : 'hFFFF;
          if (mCtl[c] & 4) begin
            wrap = (mCnt[c] == 0);
            mCnt[c] = wrap ? top : mCnt[c] - 1;
          end else begin
            wrap = (mCnt[c] >= top);
            mCnt[c] = wrap ? 0 : mCnt[c] + 1;
          end
          if (wrap) mStat[c] |= (mCtl[c] & 2) ? 1 : 16;
          if (mCtl[c] & 8)
            for (int i = 0; i < 3; i++)
              if (mMat[c][i] <= top && mMat[c][i] == mCnt[c]) mStat[c] |= (2 << i);
        end
      end
      if (busSel && busWrite && k < 11) begin
        case (k)
          0: mClk[ch]  = busWdata & 'h3F;
          1: mCtl[ch]  = busWdata & 'h2F;
          3: mIntv[ch] = busWdata & 'hFFFF;
          4, 5, 6: mMat[ch][k-4] = busWdata & 'hFFFF;
          8: mEn[ch]   = busWdata & 'h3F;
          9: mEvc[ch]  = busWdata & 'h7;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, mid-cycle
  always @(negedge clk) begin
    int exp;
    if (rstN) begin
      for (int c = 0; c < 3; c++) begin
        total++;
        if (irq[c] !== ((mStat[c] & mEn[c]) != 0)) begin
          bad++;
          $display("FAIL R7 irq[%0d] actual=%b expected=%b", c, irq[c],
                   ((mStat[c] & mEn[c]) != 0));
        end
      end
      if (busSel && !busWrite) begin
        exp = modelRead(busAddr);
        total++;
        if (busRdata !== 32'(exp)) begin
          bad++;
          $display("FAIL %s R8 addr=%02h actual=%08h expected=%08h",
                   curReq, busAddr, busRdata, exp);
        end
      end
    end
  end

  function automatic logic [7:0] adr(int k, int c);
    return 8'((3 * k + c) * 4);
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic rd(logic [7:0] a);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
  endtask

  task automatic idle(int n);
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R2: reset value of every counter control
    curReq = "R2";
    for (int c = 0; c < 3; c++) rd(adr(1, c));
    idle(2);
    // R8: full sweep of the window
    curReq = "R8";
    for (int a = 0; a <= 'h80; a += 4) rd(8'(a));
    idle(2);
    // R9: unmapped words, read-only words, field masks
    curReq = "R9";
    rd(8'h84); rd(8'hFC); wr(8'h84, 32'hFFFF_FFFF); rd(8'h84);
    wr(adr(2, 0), 32'h1234); rd(adr(2, 0));
    wr(adr(3, 0), 32'h12345); rd(adr(3, 0));
    wr(adr(8, 0), 32'hFF); rd(adr(8, 0));
    wr(adr(9, 2), 32'hFF); rd(adr(9, 2)); rd(adr(10, 2));
    wr(adr(0, 1), 32'hFFC0); rd(adr(0, 1));
    idle(2);
    // R1 R3 R5: ch0 interval 9, divide by 4, up, matches 3, 9, 12 (>limit)
    curReq = "R1";
    wr(adr(0, 0), 32'h03); wr(adr(3, 0), 32'd9);
    wr(adr(4, 0), 32'd3); wr(adr(5, 0), 32'd9); wr(adr(6, 0), 32'd12);
    wr(adr(8, 0), 32'h3F); wr(adr(1, 0), 32'h1A);
    for (int i = 0; i < 12; i++) begin idle(3); rd(adr(2, 0)); end
    curReq = "R5";
    rd(adr(7, 0)); idle(50); rd(adr(7, 0)); rd(adr(7, 0));
    curReq = "R3";
    idle(17); rd(adr(2, 0)); rd(adr(7, 0));
    // R4 R5: ch1 down, interval 5, matches 2, 0, 7 (>limit)
    curReq = "R4";
    wr(adr(3, 1), 32'd5); wr(adr(4, 1), 32'd2); wr(adr(5, 1), 32'd0);
    wr(adr(6, 1), 32'd7); wr(adr(8, 1), 32'h01); wr(adr(1, 1), 32'h1E);
    for (int i = 0; i < 10; i++) begin rd(adr(2, 1)); idle(1); end
    rd(adr(7, 1)); idle(7); rd(adr(7, 1));
    // R6: writes to status ignored, back-to-back reads with a flag every cycle
    curReq = "R6";
    idle(3); wr(adr(7, 1), 32'h3F); rd(adr(7, 1));
    wr(adr(3, 1), 32'd0); idle(8);
    for (int i = 0; i < 6; i++) rd(adr(7, 1));
    idle(2);
    // R1: second ratio, divide by 8 on ch1 (up, interval 20)
    curReq = "R1";
    wr(adr(1, 1), 32'h01); wr(adr(0, 1), 32'h05); wr(adr(3, 1), 32'd20);
    wr(adr(1, 1), 32'h12);
    for (int i = 0; i < 12; i++) begin idle(5); rd(adr(2, 1)); end
    // R3: ch2 full-range up overflow
    curReq = "R3";
    wr(adr(8, 2), 32'h10); wr(adr(1, 2), 32'h10);
    for (int i = 0; i < 17; i++) begin idle(4000); rd(adr(2, 2)); end
    rd(adr(7, 2));
    // R4: down step from zero in overflow mode
    curReq = "R4";
    wr(adr(1, 2), 32'h14); idle(3); rd(adr(2, 2)); rd(adr(7, 2));
    // R2: disable freezes, clear bit zeroes and reads back 0
    curReq = "R2";
    wr(adr(1, 0), 32'h0B); rd(adr(2, 0)); idle(10); rd(adr(2, 0));
    wr(adr(1, 0), 32'h11); rd(adr(2, 0)); rd(adr(1, 0));
    idle(5);
    summary();
    $finish;
  end
endmodule